// File: doc/BRIEF.md
# Converter Start-and-Capture Controller

This block runs an external 12-bit subranging converter from a synchronous clock domain. On each sample request it drives a start pulse whose width is a fixed number of clock cycles. That width is chosen so the pulse falls inside the window the converter allows after its rising edge. The block then waits for the converter's data-ready strobe, brings that strobe into the clock domain through a flop chain, and captures the 12 code bits and the out-of-range bit.

The captured code is recoded for the selected output format, and the range condition is split into separate over and under flags. The result is held in an output register and leaves on a valid/ready stream. Three one-cycle event outputs report faults. One reports a start request refused because a conversion is still in flight. One reports a data-ready strobe that never came. One reports a held result that was replaced before it was accepted.

A conversion is fully done only when the synchronized strobe has fallen again. Only then is a new start pulse issued.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `conv_start`, `res_valid`, `evt_drop`, `evt_timeout` and `evt_overflow` are all low.
- R2: A `sample_tick` seen while the controller is idle raises `conv_start` on the next cycle. It stays high for exactly `ENC_HIGH_CYC` cycles (default 2).
- R3: A `sample_tick` seen while a conversion is in flight produces a one-cycle `evt_drop` pulse and no extra start pulse.
- R4: `conv_done` passes through `SYNC_STAGES` flops. Only a synchronized rising edge seen while waiting after a start pulse captures `conv_code` and `conv_otr`. A rising edge at any other time produces no result.
- R5: If no synchronized rising edge of `conv_done` arrives within ceil(`CONV_MAX_NS`/`CLK_PERIOD_NS`) + `SYNC_STAGES` + 4 cycles after `conv_start` falls, the controller does three things. It pulses `evt_timeout` for one cycle, returns to idle, and produces no result. With the defaults this limit is 56 cycles.
- R6: Range flags are decoded from the captured raw bits. `conv_otr`=0 gives `res_over`=`res_under`=0. `conv_otr`=1 with raw bit 11 = 1 gives `res_over`=1. `conv_otr`=1 with raw bit 11 = 0 gives `res_under`=1. The two flags are never high together.
- R7: `fmt_sel` is sampled at capture. Code 00 (straight binary), code 01 (offset binary) and code 11 (reserved) pass the raw code unchanged. Code 10 (two's complement) inverts bit 11. For example, raw 0x800 gives 0x000 and raw 0x000 gives 0x800.
- R8: Once `res_valid` is high, it and `res_code`, `res_over` and `res_under` stay unchanged until a cycle with `res_ready` high, unless a new capture replaces them. After that accepting cycle `res_valid` is low.
- R9: A capture while an unaccepted result is held, with `res_ready` low, pulses `evt_overflow` for one cycle. The new result then replaces the old one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_tick | input | 1 | One-cycle request to start a conversion |
| fmt_sel | input | 2 | Output coding: 00 straight, 01 offset, 10 two's complement, 11 as straight |
| conv_start | output | 1 | Start pulse to the converter |
| conv_done | input | 1 | Asynchronous data-ready strobe from the converter |
| conv_code | input | CODE_W | Raw converter code |
| conv_otr | input | 1 | Converter out-of-range bit |
| res_valid | output | 1 | Result held and offered |
| res_ready | input | 1 | Consumer accepts the result |
| res_code | output | CODE_W | Recoded result |
| res_over | output | 1 | Input was above range |
| res_under | output | 1 | Input was below range |
| evt_drop | output | 1 | Start request refused (busy) |
| evt_timeout | output | 1 | Data-ready strobe did not arrive |
| evt_overflow | output | 1 | Held result was overwritten |

## Verification
The bench builds the block with its defaults: a 10 ns clock, a 2-cycle start pulse, a 500 ns worst-case conversion and 2 synchronizer stages. That gives a 56-cycle timeout, which a bench converter model with 4 to 40 cycles of latency stays well inside. Because the model can be muted, the timeout path is also reachable within a short run. The 12-bit width lets the sign-boundary codes 0x000, 0x7FF, 0x800 and 0xFFF be driven directly under every coding.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic [1:0] {
    FMT_STRAIGHT = 2'b00,
    FMT_OFFSET   = 2'b01,
    FMT_TWOS     = 2'b10,
    FMT_RSVD     = 2'b11
  } out_fmt_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'b00,
    SQ_ENC   = 2'b01,
    SQ_WAIT  = 2'b10,
    SQ_DRAIN = 2'b11
  } seq_state_e;

endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~last_q;

  // R4: a detected edge must come from the raw input STAGES cycles earlier
  p_sync_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> $past(async_i, STAGES));

endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import adc_cap_pkg::*;
#(
  parameter int ENC_HIGH_CYC = 2,
  parameter int TIMEOUT_CYC  = 56
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic dav_level_i,
  input  logic dav_rise_i,
  output logic enc_o,
  output logic cap_o,
  output logic busy_o,
  output logic evt_drop_o,
  output logic evt_timeout_o
);

  localparam int SPAN  = (ENC_HIGH_CYC > TIMEOUT_CYC) ? ENC_HIGH_CYC : TIMEOUT_CYC;
  localparam int CNT_W = $clog2(SPAN + 1);
  localparam logic [CNT_W-1:0] ENC_LAST = CNT_W'(ENC_HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT_CYC - 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             drop_q, drop_d;
  logic             to_q, to_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    to_d   = 1'b0;
    drop_d = tick_i && (st_q != SQ_IDLE);
    unique case (st_q)
      SQ_IDLE: begin
        if (tick_i) begin
          st_d  = SQ_ENC;
          cnt_d = '0;
        end
      end
      SQ_ENC: begin
        if (cnt_q == ENC_LAST) begin
          st_d  = SQ_WAIT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_WAIT: begin
        if (dav_rise_i) begin
          st_d = SQ_DRAIN;
        end else if (cnt_q == TO_LAST) begin
          st_d = SQ_IDLE;
          to_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_DRAIN: begin
        if (!dav_level_i) st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      drop_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      drop_q <= drop_d;
      to_q   <= to_d;
    end
  end

  assign enc_o         = (st_q == SQ_ENC);
  assign cap_o         = (st_q == SQ_WAIT) && dav_rise_i;
  assign busy_o        = (st_q != SQ_IDLE);
  assign evt_drop_o    = drop_q;
  assign evt_timeout_o = to_q;

  // checker support: length of the current start pulse
  logic [7:0] enc_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enc_run_q <= '0;
    else if (enc_o) enc_run_q <= enc_run_q + 8'd1;
    else            enc_run_q <= '0;
  end

  p_enc_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enc_o) |-> (enc_run_q == 8'(ENC_HIGH_CYC)));

  p_no_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && busy_o) |=> (evt_drop_o && !$rose(enc_o)));

  p_timeout_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_timeout_o |-> (!$past(cap_o) && !enc_o));

endmodule

// File: rtl/cap_fmt.sv
module cap_fmt
  import adc_cap_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic [CODE_W-1:0] raw_i,
  input  logic              otr_i,
  input  logic [1:0]        fmt_i,
  output logic [CODE_W-1:0] code_o,
  output logic              over_o,
  output logic              under_o
);

  localparam logic [CODE_W-1:0] MSB_MASK = {1'b1, {(CODE_W-1){1'b0}}};

  out_fmt_e fmt;
  assign fmt = out_fmt_e'(fmt_i);

  always_comb begin
    if (fmt == FMT_TWOS) code_o = raw_i ^ MSB_MASK;
    else                 code_o = raw_i;
    over_o  = otr_i &  raw_i[CODE_W-1];
    under_o = otr_i & ~raw_i[CODE_W-1];
  end

endmodule

// File: rtl/cap_hold.sv
module cap_hold #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              over_i,
  input  logic              under_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic              over_o,
  output logic              under_o,
  output logic              evt_ovf_o
);

  logic              v_q, v_d;
  logic [CODE_W-1:0] c_q, c_d;
  logic              ov_q, ov_d, un_q, un_d;
  logic              ovf_q, ovf_d;

  always_comb begin
    v_d   = v_q;
    c_d   = c_q;
    ov_d  = ov_q;
    un_d  = un_q;
    ovf_d = 1'b0;
    if (cap_i) begin
      v_d   = 1'b1;
      c_d   = code_i;
      ov_d  = over_i;
      un_d  = under_i;
      ovf_d = v_q && !ready_i;
    end else if (v_q && ready_i) begin
      v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      c_q   <= '0;
      ov_q  <= 1'b0;
      un_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      v_q   <= v_d;
      ovf_q <= ovf_d;
      if (cap_i) begin
        c_q  <= c_d;
        ov_q <= ov_d;
        un_q <= un_d;
      end
    end
  end

  assign valid_o   = v_q;
  assign code_o    = c_q;
  assign over_o    = ov_q;
  assign under_o   = un_q;
  assign evt_ovf_o = ovf_q;

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !cap_i) |=> (valid_o && $stable(code_o) && $stable(over_o) && $stable(under_o)));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && !cap_i) |=> !valid_o);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && valid_o && !ready_i) |=> evt_ovf_o);

  p_range_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({over_o, under_o}));

endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl #(
  parameter int CODE_W        = 12,
  parameter int CLK_PERIOD_NS = 10,
  parameter int ENC_HIGH_CYC  = 2,
  parameter int CONV_MAX_NS   = 500,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic [1:0]        fmt_sel,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [CODE_W-1:0] conv_code,
  input  logic              conv_otr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CODE_W-1:0] res_code,
  output logic              res_over,
  output logic              res_under,
  output logic              evt_drop,
  output logic              evt_timeout,
  output logic              evt_overflow
);

  localparam int TIMEOUT_CYC =
    (CONV_MAX_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS + SYNC_STAGES + 4;

  logic              dav_level, dav_rise;
  logic              cap, busy;
  logic [CODE_W-1:0] fmt_code;
  logic              fmt_over, fmt_under;

  cap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (conv_done),
    .level_o (dav_level),
    .rise_o  (dav_rise)
  );

  cap_seq #(
    .ENC_HIGH_CYC (ENC_HIGH_CYC),
    .TIMEOUT_CYC  (TIMEOUT_CYC)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (sample_tick),
    .dav_level_i   (dav_level),
    .dav_rise_i    (dav_rise),
    .enc_o         (conv_start),
    .cap_o         (cap),
    .busy_o        (busy),
    .evt_drop_o    (evt_drop),
    .evt_timeout_o (evt_timeout)
  );

  cap_fmt #(.CODE_W(CODE_W)) u_fmt (
    .raw_i   (conv_code),
    .otr_i   (conv_otr),
    .fmt_i   (fmt_sel),
    .code_o  (fmt_code),
    .over_o  (fmt_over),
    .under_o (fmt_under)
  );

  cap_hold #(.CODE_W(CODE_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (cap),
    .code_i    (fmt_code),
    .over_i    (fmt_over),
    .under_i   (fmt_under),
    .ready_i   (res_ready),
    .valid_o   (res_valid),
    .code_o    (res_code),
    .over_o    (res_over),
    .under_o   (res_under),
    .evt_ovf_o (evt_overflow)
  );

  // R4: a result only appears after a capture while a conversion was pending
  p_result_needs_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(busy));

endmodule

// File: tb/adc_capture_ctrl_tb.sv
module adc_capture_ctrl_tb;

  localparam int CLK_NS  = 10;
  localparam int ENC_CYC = 2;
  localparam int TO_EXP  = (500 + CLK_NS - 1) / CLK_NS + 2 + 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_tick;
  logic [1:0]  fmt_sel;
  logic        conv_start;
  logic        model_dav, force_dav;
  logic        conv_done;
  logic [11:0] conv_code;
  logic        conv_otr;
  logic        res_valid, res_ready;
  logic [11:0] res_code;
  logic        res_over, res_under;
  logic        evt_drop, evt_timeout, evt_overflow;

  assign conv_done = model_dav | force_dav;

  adc_capture_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .fmt_sel(fmt_sel),
    .conv_start(conv_start), .conv_done(conv_done), .conv_code(conv_code),
    .conv_otr(conv_otr), .res_valid(res_valid), .res_ready(res_ready),
    .res_code(res_code), .res_over(res_over), .res_under(res_under),
    .evt_drop(evt_drop), .evt_timeout(evt_timeout), .evt_overflow(evt_overflow)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_code(input logic [11:0] raw, input logic [1:0] f);
    return (f == 2'b10) ? (raw ^ 12'h800) : raw;
  endfunction

  // converter model
  logic [11:0] m_code;
  logic        m_otr;
  int          m_lat;
  bit          mute;
  int          cd, hold;
  bit          enc_prev;

  // event monitor
  int n_rise, n_drop, n_to, n_ovf, run, last_width;

  initial begin
    cd = 0; hold = 0; enc_prev = 0; model_dav = 0; conv_code = '0; conv_otr = 0;
    n_rise = 0; n_drop = 0; n_to = 0; n_ovf = 0; run = 0; last_width = 0;
  end

  always @(negedge clk) begin
    if (conv_start && !enc_prev && !mute) cd = m_lat;
    enc_prev = conv_start;
    if (cd > 0) begin
      cd--;
      if (cd == 2) begin conv_code = m_code; conv_otr = m_otr; end
      if (cd == 0) begin model_dav = 1'b1; hold = 12; end
    end else if (hold > 0) begin
      hold--;
      if (hold == 0) model_dav = 1'b0;
    end
    if (conv_start) run++;
    else if (run > 0) begin last_width = run; run = 0; n_rise++; end
    if (evt_drop)     n_drop++;
    if (evt_timeout)  n_to++;
    if (evt_overflow) n_ovf++;
  end

  task automatic start_conv(input logic [11:0] c, input logic o, input logic [1:0] f, input int lat);
    m_code = c; m_otr = o; m_lat = lat; fmt_sel = f;
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    for (int i = 0; i < 200 && !(cd == 0 && hold == 0 && !model_dav && !conv_start); i++)
      @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic accept();
    @(negedge clk) res_ready = 1'b1;
    @(negedge clk) res_ready = 1'b0;
  endtask

  task automatic check_result(input logic [11:0] c, input logic o, input logic [1:0] f, input string req);
    check(res_valid == 1'b1, req, res_valid, 1);
    check(res_code == exp_code(c, f), req, res_code, exp_code(c, f));
    check({res_over, res_under} == {o & c[11], o & ~c[11]}, "R6", {res_over, res_under},
          {o & c[11], o & ~c[11]});
  endtask

  initial begin
    int base;
    int k;
    logic [11:0] rc;
    logic        ro;
    logic [1:0]  rf;
    int          rl;
    void'($urandom(32'h5A17));
    rst_n = 1'b0; sample_tick = 0; fmt_sel = 0; res_ready = 0; force_dav = 0; mute = 0;
    m_code = 0; m_otr = 0; m_lat = 8;
    repeat (3) @(negedge clk);
    check({conv_start, res_valid, evt_drop, evt_timeout, evt_overflow} == 5'b0, "R1 in reset",
          {conv_start, res_valid, evt_drop, evt_timeout, evt_overflow}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({conv_start, res_valid, evt_drop, evt_timeout, evt_overflow} == 5'b0, "R1 after reset",
          {conv_start, res_valid, evt_drop, evt_timeout, evt_overflow}, 0);

    // R2: start pulse begins next cycle and has fixed width
    m_code = 12'h123; m_otr = 0; m_lat = 10; fmt_sel = 2'b00;
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    check(conv_start == 1'b1, "R2 start after tick", conv_start, 1);
    repeat (ENC_CYC + 2) @(negedge clk);
    check(last_width == ENC_CYC, "R2 width", last_width, ENC_CYC);
    repeat (40) @(negedge clk);
    check_result(12'h123, 1'b0, 2'b00, "R4 capture");
    accept();
    check(res_valid == 1'b0, "R8 released", res_valid, 0);

    // R7 boundary codes under each coding
    start_conv(12'h800, 0, 2'b10, 6);  check_result(12'h800, 0, 2'b10, "R7 twos 0x800"); accept();
    start_conv(12'h000, 0, 2'b10, 6);  check_result(12'h000, 0, 2'b10, "R7 twos 0x000"); accept();
    start_conv(12'h7FF, 0, 2'b01, 6);  check_result(12'h7FF, 0, 2'b01, "R7 offset");     accept();
    start_conv(12'hFFF, 0, 2'b11, 6);  check_result(12'hFFF, 0, 2'b11, "R7 reserved");   accept();
    // R6 range decode
    start_conv(12'hFFF, 1, 2'b00, 9);  check_result(12'hFFF, 1, 2'b00, "R6 over");  accept();
    start_conv(12'h000, 1, 2'b10, 9);  check_result(12'h000, 1, 2'b10, "R6 under"); accept();

    // R3: tick while busy
    base = n_rise;
    m_code = 12'h0AA; m_otr = 0; m_lat = 30; fmt_sel = 2'b00;
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    repeat (8) @(negedge clk);
    k = n_drop;
    sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    @(negedge clk);
    check(n_drop == k + 1, "R3 drop pulse", n_drop, k + 1);
    repeat (60) @(negedge clk);
    check(n_rise == base + 1, "R3 no extra start", n_rise - base, 1);
    check_result(12'h0AA, 0, 2'b00, "R3 result kept");
    accept();

    // R4: strobe while idle is ignored
    repeat (5) @(negedge clk);
    force_dav = 1'b1;
    repeat (6) @(negedge clk);
    force_dav = 1'b0;
    repeat (6) @(negedge clk);
    check(res_valid == 1'b0, "R4 idle strobe ignored", res_valid, 0);

    // R5: timeout
    mute = 1; k = n_to;
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    while (conv_start) @(negedge clk);
    base = 0;
    while (!evt_timeout && base < TO_EXP + 20) begin base++; @(negedge clk); end
    check(base >= TO_EXP - 1 && base <= TO_EXP + 1, "R5 timeout cycles", base, TO_EXP);
    @(negedge clk);
    check(n_to == k + 1, "R5 single pulse", n_to - k, 1);
    check(res_valid == 1'b0, "R5 no result", res_valid, 0);
    mute = 0;
    repeat (4) @(negedge clk);

    // R9: overflow
    k = n_ovf;
    start_conv(12'h111, 0, 2'b00, 7);
    start_conv(12'h222, 1, 2'b00, 7);
    check(n_ovf == k + 1, "R9 overflow pulse", n_ovf - k, 1);
    check_result(12'h222, 1, 2'b00, "R9 replaced");
    accept();

    // random mix with R8 hold checks
    for (int it = 0; it < 40; it++) begin
      rc = 12'($urandom);
      ro = ($urandom % 4) == 0;
      rf = 2'($urandom);
      rl = 4 + int'($urandom % 37);
      start_conv(rc, ro, rf, rl);
      check_result(rc, ro, rf, "R7 random");
      repeat (int'($urandom % 5)) @(negedge clk);
      check(res_valid && res_code == exp_code(rc, rf), "R8 held", res_code, exp_code(rc, rf));
      accept();
      check(res_valid == 1'b0, "R8 released", res_valid, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule